// File: doc/BRIEF.md
# Latch Input Edge Timestamp Unit

This block records the value of a free-running system time bus when something happens on one of a small set of external event pins. Each pin passes through a two-stage synchronizer. Its rising and its falling transitions are then stamped into two separate 64-bit registers. A fifth register stamps pulses from an internal buffer-manager event line, which is useful when debugging data exchange timing.

Each stamp register has a pending flag. The flag is raised when a stamp is taken and cleared when the host reads that register through a simple select/enable read port. Each pin can run in continuous mode, where every edge overwrites the stamp, or in single-shot mode, where the first stamp is held until it has been read.

A pin that is shared with a sync output only takes stamps while its routing configuration marks it as a latch input. A power-save input suppresses all pin captures but leaves the internal event capture working.

Top module: `latch_stamp_unit`

## Requirements
- R1: After synchronous reset every pending flag is 0, `rd_data` is 0, and every stamp register reads back as 0.
- R2: A rising transition on `latch_pin[i]` stores the value `sys_time` holds in the cycle when the synchronized edge is seen, which is two cycles after the pin change is first sampled. The pending flag is visible after the third rising clock edge.
- R3: A falling transition on `latch_pin[i]` is stored in a register separate from the rising one, and it leaves the rising register unchanged.
- R4: Register k's flag is `evt_flags[k]`. A read with `rd_en`=1 and `rd_sel`=k puts the stamp on `rd_data` one cycle later and clears only flag k.
- R5: When `single_shot[i]`=0 (continuous mode), every new edge of the same polarity overwrites the stamp.
- R6: When `single_shot[i]`=1, a stamp whose flag is pending is not overwritten by later edges. After it has been read, the next edge is captured again.
- R7: When `pin_is_latch[i]`=0 (pin routed as sync output), edges on that pin cause no capture and set no flag.
- R8: When `latch_pwr_save`=1, no pin edge is captured, while internal buffer events are still captured.
- R9: A one-cycle `buf_evt` pulse stores the `sys_time` value of that same cycle into register 2N and sets flag 2N.
- R10: If a capture and a read of the same register fall in the same cycle, the read returns the old stamp, the new stamp is stored, and the flag stays set.
- R11: Select encoding is `rd_sel` = 2*i for the rising edge of pin i, 2*i+1 for its falling edge, and 2N for the buffer event. Any other select value reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_time | input | 64 | Current system time |
| latch_pin | input | N_LATCH | Asynchronous external event pins |
| pin_is_latch | input | N_LATCH | 1 = shared pin configured as latch input |
| latch_pwr_save | input | 1 | 1 = pin captures disabled |
| single_shot | input | N_LATCH | Per-pin single-shot mode select |
| buf_evt | input | 1 | Internal buffer-manager event pulse |
| rd_en | input | 1 | Read strobe, clears the selected flag |
| rd_sel | input | SEL_W | Register select |
| rd_data | output | 64 | Registered read data |
| evt_flags | output | 2*N_LATCH+1 | Pending flag per stamp register |

## Verification
A wrong synchronizer depth or a wrong edge polarity shows up as a stamp that is off by whole cycles, or as a flag in the wrong bit, on the first edge after reset. That is three clock edges after the pin moves. A flag that fails to clear, or a gating fault, shows up as a non-zero `evt_flags` at the check that follows each read or each masked toggle. A broken single-shot hold or a broken read/capture priority is only seen on the read that follows a second event, so the bench provokes those pairs explicitly.

// File: rtl/latch_stamp_pkg.sv
package latch_stamp_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    typedef struct packed {
        logic take;
        logic one_shot;
        logic clr;
    } cap_ctrl_t;

    function automatic int stamp_index(input int lane, input edge_kind_e kind);
        return 2 * lane + ((kind == EDGE_FALL) ? 1 : 0);
    endfunction

endpackage

// File: rtl/pin_edge_sense.sv
module pin_edge_sense #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign rise[i] = sync_q[i] & ~prev_q[i];
        assign fall[i] = ~sync_q[i] & prev_q[i];

        // R2
        rise_latency_chk: assert property (@(posedge clk) disable iff (rst)
            rise[i] |-> $past(pin[i], 2));
        // R3
        fall_latency_chk: assert property (@(posedge clk) disable iff (rst)
            fall[i] |-> !$past(pin[i], 2));
    end
endmodule

// File: rtl/stamp_slot.sv
module stamp_slot
    import latch_stamp_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              one_shot,
    input  logic              clr,
    input  logic [TIME_W-1:0] time_in,
    output logic [TIME_W-1:0] stamp,
    output logic              pending
);
    cap_ctrl_t ctl;

    always_comb begin
        ctl.one_shot = one_shot;
        ctl.clr      = clr;
        ctl.take     = cap & ~(one_shot & pending);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp   <= '0;
            pending <= 1'b0;
        end else begin
            if (ctl.take) stamp <= time_in;
            if (ctl.take) pending <= 1'b1;
            else if (ctl.clr) pending <= 1'b0;
        end
    end

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cap && !one_shot) |=> pending);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (one_shot && pending) |=> $stable(stamp));
    // R10
    cap_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (cap && clr && !one_shot) |=> (pending && stamp == $past(time_in)));
endmodule

// File: rtl/latch_stamp_unit.sv
module latch_stamp_unit
    import latch_stamp_pkg::*;
#(
    parameter int N_LATCH = 2,
    parameter int TIME_W  = 64,
    localparam int NREG   = 2 * N_LATCH + 1,
    localparam int SEL_W  = $clog2(NREG + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TIME_W-1:0]  sys_time,
    input  logic [N_LATCH-1:0] latch_pin,
    input  logic [N_LATCH-1:0] pin_is_latch,
    input  logic               latch_pwr_save,
    input  logic [N_LATCH-1:0] single_shot,
    input  logic               buf_evt,
    input  logic               rd_en,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [TIME_W-1:0]  rd_data,
    output logic [NREG-1:0]    evt_flags
);
    localparam int BUF_IDX = NREG - 1;

    logic [N_LATCH-1:0] rise;
    logic [N_LATCH-1:0] fall;
    logic [N_LATCH-1:0] lane_ok;
    logic [NREG-1:0]    cap_vec;
    logic [NREG-1:0]    shot_vec;
    logic [NREG-1:0]    clr_vec;
    logic [TIME_W-1:0]  stamps [NREG];
    logic [TIME_W-1:0]  rd_mux;

    pin_edge_sense #(.N(N_LATCH)) u_sense (
        .clk  (clk),
        .rst  (rst),
        .pin  (latch_pin),
        .rise (rise),
        .fall (fall)
    );

    assign lane_ok = pin_is_latch & {N_LATCH{~latch_pwr_save}};

    for (genvar i = 0; i < N_LATCH; i++) begin : g_lane
        localparam int RI = stamp_index(i, EDGE_RISE);
        localparam int FI = stamp_index(i, EDGE_FALL);
        assign cap_vec[RI]  = rise[i] & lane_ok[i];
        assign cap_vec[FI]  = fall[i] & lane_ok[i];
        assign shot_vec[RI] = single_shot[i];
        assign shot_vec[FI] = single_shot[i];

        // R7
        gated_pin_chk: assert property (@(posedge clk) disable iff (rst)
            !pin_is_latch[i] |=> (!$rose(evt_flags[RI]) && !$rose(evt_flags[FI])));
    end

    assign cap_vec[BUF_IDX]  = buf_evt;
    assign shot_vec[BUF_IDX] = 1'b0;

    for (genvar k = 0; k < NREG; k++) begin : g_slot
        assign clr_vec[k] = rd_en && (rd_sel == SEL_W'(k));
        stamp_slot #(.TIME_W(TIME_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .cap      (cap_vec[k]),
            .one_shot (shot_vec[k]),
            .clr      (clr_vec[k]),
            .time_in  (sys_time),
            .stamp    (stamps[k]),
            .pending  (evt_flags[k])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NREG; k++) begin
            if (rd_sel == SEL_W'(k)) rd_mux = stamps[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    // R8
    pwr_save_chk: assert property (@(posedge clk) disable iff (rst)
        latch_pwr_save |=>
            ((evt_flags[NREG-2:0] & ~$past(evt_flags[NREG-2:0])) == '0));
    // R9
    buf_capture_chk: assert property (@(posedge clk) disable iff (rst)
        buf_evt |=> evt_flags[BUF_IDX]);
    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_W'(BUF_IDX) && !buf_evt) |=> !evt_flags[BUF_IDX]);
endmodule

// File: tb/tb_latch_stamp_unit.sv
module tb_latch_stamp_unit;
    localparam int NL = 2;
    localparam int TW = 64;
    localparam int NR = 2 * NL + 1;
    localparam int SW = $clog2(NR + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] sys_time = 64'h0000_0001_0000_0000;
    logic [NL-1:0] latch_pin = '0;
    logic [NL-1:0] pin_is_latch = '1;
    logic          latch_pwr_save = 1'b0;
    logic [NL-1:0] single_shot = '0;
    logic          buf_evt = 1'b0;
    logic          rd_en = 1'b0;
    logic [SW-1:0] rd_sel = '0;
    logic [TW-1:0] rd_data;
    logic [NR-1:0] evt_flags;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;
    always @(posedge clk) sys_time <= sys_time + 64'd1;

    latch_stamp_unit #(.N_LATCH(NL), .TIME_W(TW)) dut (
        .clk(clk), .rst(rst), .sys_time(sys_time), .latch_pin(latch_pin),
        .pin_is_latch(pin_is_latch), .latch_pwr_save(latch_pwr_save),
        .single_shot(single_shot), .buf_evt(buf_evt), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_data(rd_data), .evt_flags(evt_flags)
    );

    typedef struct packed {
        logic [1:0] pins;
        logic [2:0] sel;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'b01, 3'd0}, '{2'b11, 3'd2}, '{2'b10, 3'd1},
        '{2'b00, 3'd3}, '{2'b01, 3'd0}, '{2'b00, 3'd1}
    };

    task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(input int sel, output logic [TW-1:0] d);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_sel = SW'(sel);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic set_pin(input int idx, input logic v, output logic [TW-1:0] t);
        @(negedge clk);
        latch_pin[idx] = v;
        t = sys_time;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [TW-1:0] d, t1, t2, t3, tx;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", TW'(evt_flags), '0);
        chk("R1 rd_data", rd_data, '0);
        do_read(0, d);
        chk("R1 stamp0", d, '0);

        // table walk: R2/R3/R4/R11 per edge and register
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            latch_pin = VEC[i].pins;
            t1 = sys_time;
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk("R4 flag set", TW'(evt_flags[VEC[i].sel]), 1);
            do_read(int'(VEC[i].sel), d);
            chk("R2/R3/R11 stamp", d, t1 + 64'd2);
            chk("R4 flags cleared", TW'(evt_flags), '0);
        end

        // R5 continuous overwrite, R3 rising untouched by fall
        set_pin(0, 1'b1, t1);
        set_pin(0, 1'b0, t2);
        set_pin(0, 1'b1, t3);
        do_read(0, d);
        chk("R5 overwrite", d, t3 + 64'd2);
        do_read(1, d);
        chk("R3 fall stamp", d, t2 + 64'd2);
        do_read(0, d);
        chk("R3 rise kept", d, t3 + 64'd2);

        // R6 single-shot hold
        single_shot = 2'b01;
        set_pin(0, 1'b0, tx);
        do_read(1, d);
        set_pin(0, 1'b1, t1);
        set_pin(0, 1'b0, tx);
        do_read(1, d);
        set_pin(0, 1'b1, t2);
        do_read(0, d);
        chk("R6 first kept", d, t1 + 64'd2);
        set_pin(0, 1'b0, tx);
        do_read(1, d);
        set_pin(0, 1'b1, t3);
        do_read(0, d);
        chk("R6 rearmed", d, t3 + 64'd2);
        single_shot = 2'b00;

        // R7 pin routed as sync output
        pin_is_latch = 2'b01;
        set_pin(1, 1'b1, tx);
        set_pin(1, 1'b0, tx);
        chk("R7 no capture", TW'(evt_flags), '0);
        pin_is_latch = 2'b11;

        // R8 power save, R9 buffer event
        latch_pwr_save = 1'b1;
        set_pin(0, 1'b0, tx);
        chk("R8 pin masked", TW'(evt_flags), '0);
        @(negedge clk);
        buf_evt = 1'b1;
        t1 = sys_time;
        @(negedge clk);
        buf_evt = 1'b0;
        chk("R8 buffer still captured", TW'(evt_flags), 64'h10);
        do_read(4, d);
        chk("R9 buffer stamp", d, t1);
        latch_pwr_save = 1'b0;
        repeat (4) @(posedge clk);
        chk("R8 no late capture", TW'(evt_flags), '0);

        // R10 capture and read of same register in one cycle
        @(negedge clk);
        buf_evt = 1'b1;
        t1 = sys_time;
        @(negedge clk);
        buf_evt = 1'b0;
        rd_en = 1'b1;
        rd_sel = SW'(4);
        buf_evt = 1'b1;
        t2 = sys_time;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        buf_evt = 1'b0;
        chk("R10 old stamp read", rd_data, t1);
        chk("R10 flag kept", TW'(evt_flags[4]), 1);
        do_read(4, d);
        chk("R10 new stamp", d, t2);

        // R11 unused selects
        for (int s = NR; s < (1 << SW); s++) begin
            do_read(s, d);
            chk("R11 unused select", d, '0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule